// File: doc/BRIEF.md
# USB Debug Port Controller

This block shares one USB root port between the normal host schedule and a debug channel, and it runs debug OUT transactions. Five control and status bits select the operating mode of the port and the kind of keepalive it needs. They are the owner bit, debug enable, port enable, run/stop and suspend. The decoded mode is registered and presented to the rest of the port logic. It says whether normal traffic flows, whether SYNC-only or SOF-only keepalives are required, whether debug traffic may be sent, and whether the combination is illegal.

Software loads a transaction image in one write. The image holds the device address, the endpoint, a 16-bit PID word, a byte count, a 64-bit data buffer, a write/read bit and a start bit. When the start bit is set and the mode permits debug traffic, the block streams the token packet and then the data packet as bytes to a downstream serializer. The serializer adds CRC, stuffing and line coding. The block then waits a bounded time for a handshake and reports completion or timeout.

Top module: `usb_dbg_port_ctrl`

## Requirements
- R1: When `owner` is 0, or `dbg_en` is 0, `port_mode` becomes 0 (normal traffic only) one cycle after the inputs change.
- R2: With `owner`=1, `dbg_en`=1 and `port_en`=0, `port_mode` is 1 with `ka_sync`=1 when `run_stop`=0. It is 2 with `ka_sof`=1 when `run_stop`=1. `suspend` has no effect. `ka_sync` and `ka_sof` are never both 1.
- R3: With `owner`=1, `dbg_en`=1 and `port_en`=1: `suspend`=1 gives `port_mode` 5 whatever `run_stop` is. `suspend`=0 with `run_stop`=0 gives `port_mode` 4 with `mode_illegal`=1 and no keepalive. `suspend`=0 with `run_stop`=1 gives `port_mode` 3 with `ka_sof`=1.
- R4: `dbg_traffic_ok` is 1 only in modes 1, 2 and 3. A pending start in any other mode sends no byte and stays pending (`go_busy`=1) until the mode permits traffic.
- R5: A `cfg_load` pulse with `cfg_go`=1 and `cfg_write`=1 sets `go_busy` on the next edge. With `cfg_write`=0, `go_busy` stays 0 and no byte is sent.
- R6: The token packet is three bytes: `cfg_pids[7:0]`, then `{cfg_endp[0], cfg_addr[6:0]}`, then `{5'b0, cfg_endp[3:1]}`. `tx_last` is 1 only on the third byte.
- R7: The data packet follows: `cfg_pids[15:8]`, then `cfg_len` buffer bytes, least significant first from `cfg_data[7:0]`. `tx_last` marks the final byte, which is the PID byte when `cfg_len` is 0.
- R8: A start with `cfg_len` above 8 sets `err_len`, sends no byte and clears `go_busy`.
- R9: While `tx_valid`=1 and `tx_ready`=0, `tx_valid` and `tx_data` hold their values.
- R10: A `hs_valid` pulse in any of the TIMEOUT_CYC cycles after the last data byte is accepted sets `done` and then clears `go_busy`. A handshake in the final window cycle wins over the timeout.
- R11: With no handshake in that window, `err_timeout` sets and `go_busy` clears. A later handshake is ignored.
- R12: A `cfg_load` while `go_busy`=1 is ignored. The pending transaction sends its original image.
- R13: An accepted start clears `done`, `err_len` and `err_timeout` on the same edge that sets `go_busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| owner | input | 1 | Debug ownership of the port |
| dbg_en | input | 1 | Debug port enabled |
| port_en | input | 1 | Root port enable |
| run_stop | input | 1 | Host controller running |
| suspend | input | 1 | Port suspended |
| cfg_load | input | 1 | Load transaction image (one-cycle pulse) |
| cfg_addr | input | 7 | Device address |
| cfg_endp | input | 4 | Endpoint number |
| cfg_pids | input | 16 | [7:0] token PID, [15:8] data PID |
| cfg_len | input | 4 | Data byte count |
| cfg_data | input | 64 | Data buffer |
| cfg_write | input | 1 | 1 = OUT transaction |
| cfg_go | input | 1 | Start request |
| tx_valid | output | 1 | Byte valid toward serializer |
| tx_data | output | 8 | Byte toward serializer |
| tx_last | output | 1 | Final byte of current packet |
| tx_ready | input | 1 | Serializer accepts byte |
| hs_valid | input | 1 | Handshake received |
| port_mode | output | 3 | 0 normal, 1 SYNC keepalive, 2 SOF only, 3 interleaved, 4 illegal, 5 suspended |
| ka_sync | output | 1 | SYNC keepalives required |
| ka_sof | output | 1 | SOF keepalives required |
| dbg_traffic_ok | output | 1 | Debug traffic permitted |
| mode_illegal | output | 1 | Illegal control combination |
| go_busy | output | 1 | Start bit pending |
| done | output | 1 | Transaction completed with handshake |
| err_len | output | 1 | Byte count out of range |
| err_timeout | output | 1 | No handshake in window |

## Verification
The handshake and the timeout can fall in the same cycle. The bench notes the edge on which the final data byte is accepted. It then places `hs_valid` on the last cycle of the window, where `done` must win. In another run it places the pulse one cycle later, where `err_timeout` must win and the late pulse must leave `done` at 0. A second collision, a new load arriving while a start is pending, is provoked in the illegal mode. There the held image is judged against the bytes that flow once the mode turns legal.

// File: rtl/usb_dbg_pkg.sv
package usb_dbg_pkg;

  typedef enum logic [2:0] {
    PM_NORMAL     = 3'd0,
    PM_SYNC_KA    = 3'd1,
    PM_SOF_ONLY   = 3'd2,
    PM_INTERLEAVE = 3'd3,
    PM_ILLEGAL    = 3'd4,
    PM_SUSPEND    = 3'd5
  } port_mode_e;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_TOKPID, SQ_TOKB0, SQ_TOKB1, SQ_DATPID, SQ_DATA, SQ_WAIT
  } seq_state_e;

  function automatic port_mode_e decode_mode(input logic own, input logic en,
                                             input logic pe, input logic rs,
                                             input logic sus);
    port_mode_e m;
    if (!own || !en)  m = PM_NORMAL;
    else if (!pe)     m = rs ? PM_SOF_ONLY : PM_SYNC_KA;
    else if (sus)     m = PM_SUSPEND;
    else              m = rs ? PM_INTERLEAVE : PM_ILLEGAL;
    return m;
  endfunction

endpackage

// File: rtl/dbg_mode_sel.sv
module dbg_mode_sel
  import usb_dbg_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       owner,
  input  logic       dbg_en,
  input  logic       port_en,
  input  logic       run_stop,
  input  logic       suspend,
  output logic [2:0] mode_o,
  output logic       ka_sync_o,
  output logic       ka_sof_o,
  output logic       traffic_ok_o,
  output logic       illegal_o
);
  port_mode_e nxt;

  always_comb nxt = decode_mode(owner, dbg_en, port_en, run_stop, suspend);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_o       <= PM_NORMAL;
      ka_sync_o    <= 1'b0;
      ka_sof_o     <= 1'b0;
      traffic_ok_o <= 1'b0;
      illegal_o    <= 1'b0;
    end else begin
      mode_o       <= nxt;
      ka_sync_o    <= (nxt == PM_SYNC_KA);
      ka_sof_o     <= (nxt == PM_SOF_ONLY) || (nxt == PM_INTERLEAVE);
      traffic_ok_o <= (nxt == PM_SYNC_KA) || (nxt == PM_SOF_ONLY) ||
                      (nxt == PM_INTERLEAVE);
      illegal_o    <= (nxt == PM_ILLEGAL);
    end
  end
endmodule

// File: rtl/dbg_xact_regs.sv
module dbg_xact_regs #(
  parameter int ADDR_W = 7,
  parameter int EP_W   = 4,
  parameter int LEN_W  = 4,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [EP_W-1:0]   ep_i,
  input  logic [15:0]       pids_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              write_i,
  input  logic              go_i,
  input  logic              go_clr,
  output logic [ADDR_W-1:0] addr_o,
  output logic [EP_W-1:0]   ep_o,
  output logic [15:0]       pids_o,
  output logic [LEN_W-1:0]  len_o,
  output logic [DATA_W-1:0] data_o,
  output logic              go_o,
  output logic              start_o
);
  logic accept;

  assign accept  = load && !go_o;
  assign start_o = accept && go_i && write_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_o <= '0;
      ep_o   <= '0;
      pids_o <= '0;
      len_o  <= '0;
      data_o <= '0;
      go_o   <= 1'b0;
    end else if (accept) begin
      addr_o <= addr_i;
      ep_o   <= ep_i;
      pids_o <= pids_i;
      len_o  <= len_i;
      data_o <= data_i;
      go_o   <= go_i && write_i;
    end else if (go_clr) begin
      go_o   <= 1'b0;
    end
  end
endmodule

// File: rtl/dbg_out_seq.sv
module dbg_out_seq
  import usb_dbg_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int EP_W        = 4,
  parameter int DATA_BYTES  = 8,
  parameter int TIMEOUT_CYC = 16,
  localparam int LEN_W      = $clog2(DATA_BYTES + 1),
  localparam int IDX_W      = $clog2(DATA_BYTES),
  localparam int DATA_W     = DATA_BYTES * 8,
  localparam int TO_W       = $clog2(TIMEOUT_CYC + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic              start,
  input  logic              traffic_ok,
  input  logic [ADDR_W-1:0] addr,
  input  logic [EP_W-1:0]   ep,
  input  logic [15:0]       pids,
  input  logic [LEN_W-1:0]  len,
  input  logic [DATA_W-1:0] data,
  input  logic              tx_ready,
  input  logic              hs_valid,
  output logic              tx_valid,
  output logic [7:0]        tx_data,
  output logic              tx_last,
  output logic              go_clr,
  output logic              done,
  output logic              err_len,
  output logic              err_to
);
  seq_state_e       state;
  logic [LEN_W-1:0] idx;
  logic [TO_W-1:0]  cnt;
  logic [7:0]       dbyte [DATA_BYTES];

  for (genvar g = 0; g < DATA_BYTES; g++) begin : g_bytes
    assign dbyte[g] = data[g*8 +: 8];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= SQ_IDLE;
      tx_valid <= 1'b0;
      tx_data  <= '0;
      tx_last  <= 1'b0;
      idx      <= '0;
      cnt      <= '0;
      go_clr   <= 1'b0;
      done     <= 1'b0;
      err_len  <= 1'b0;
      err_to   <= 1'b0;
    end else begin
      go_clr <= 1'b0;
      if (start) begin
        done    <= 1'b0;
        err_len <= 1'b0;
        err_to  <= 1'b0;
      end
      case (state)
        SQ_IDLE: if (go && traffic_ok && !go_clr) begin
          if (len > LEN_W'(DATA_BYTES)) begin
            err_len <= 1'b1;
            go_clr  <= 1'b1;
          end else begin
            tx_valid <= 1'b1;
            tx_data  <= pids[7:0];
            tx_last  <= 1'b0;
            state    <= SQ_TOKPID;
          end
        end
        SQ_TOKPID: if (tx_ready) begin
          tx_data <= {ep[0], addr};
          state   <= SQ_TOKB0;
        end
        SQ_TOKB0: if (tx_ready) begin
          tx_data <= {{(8 - EP_W + 1){1'b0}}, ep[EP_W-1:1]};
          tx_last <= 1'b1;
          state   <= SQ_TOKB1;
        end
        SQ_TOKB1: if (tx_ready) begin
          tx_data <= pids[15:8];
          tx_last <= (len == '0);
          idx     <= '0;
          state   <= SQ_DATPID;
        end
        SQ_DATPID: if (tx_ready) begin
          if (len == '0) begin
            tx_valid <= 1'b0;
            tx_last  <= 1'b0;
            cnt      <= '0;
            state    <= SQ_WAIT;
          end else begin
            tx_data <= dbyte[0];
            tx_last <= (len == LEN_W'(1));
            idx     <= LEN_W'(1);
            state   <= SQ_DATA;
          end
        end
        SQ_DATA: if (tx_ready) begin
          if (tx_last) begin
            tx_valid <= 1'b0;
            tx_last  <= 1'b0;
            cnt      <= '0;
            state    <= SQ_WAIT;
          end else begin
            tx_data <= dbyte[idx[IDX_W-1:0]];
            tx_last <= ((idx + LEN_W'(1)) == len);
            idx     <= idx + LEN_W'(1);
          end
        end
        SQ_WAIT: begin
          if (hs_valid) begin
            done   <= 1'b1;
            go_clr <= 1'b1;
            state  <= SQ_IDLE;
          end else if (cnt == TO_W'(TIMEOUT_CYC - 1)) begin
            err_to <= 1'b1;
            go_clr <= 1'b1;
            state  <= SQ_IDLE;
          end else begin
            cnt <= cnt + TO_W'(1);
          end
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/usb_dbg_port_ctrl.sv
module usb_dbg_port_ctrl #(
  parameter int ADDR_W      = 7,
  parameter int EP_W        = 4,
  parameter int DATA_BYTES  = 8,
  parameter int TIMEOUT_CYC = 16,
  localparam int LEN_W      = $clog2(DATA_BYTES + 1),
  localparam int DATA_W     = DATA_BYTES * 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              owner,
  input  logic              dbg_en,
  input  logic              port_en,
  input  logic              run_stop,
  input  logic              suspend,
  input  logic              cfg_load,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [EP_W-1:0]   cfg_endp,
  input  logic [15:0]       cfg_pids,
  input  logic [LEN_W-1:0]  cfg_len,
  input  logic [DATA_W-1:0] cfg_data,
  input  logic              cfg_write,
  input  logic              cfg_go,
  output logic              tx_valid,
  output logic [7:0]        tx_data,
  output logic              tx_last,
  input  logic              tx_ready,
  input  logic              hs_valid,
  output logic [2:0]        port_mode,
  output logic              ka_sync,
  output logic              ka_sof,
  output logic              dbg_traffic_ok,
  output logic              mode_illegal,
  output logic              go_busy,
  output logic              done,
  output logic              err_len,
  output logic              err_timeout
);
  logic [ADDR_W-1:0] r_addr;
  logic [EP_W-1:0]   r_ep;
  logic [15:0]       r_pids;
  logic [LEN_W-1:0]  r_len;
  logic [DATA_W-1:0] r_data;
  logic              start, go_clr;

  dbg_mode_sel u_mode (
    .clk, .rst, .owner, .dbg_en, .port_en, .run_stop, .suspend,
    .mode_o(port_mode), .ka_sync_o(ka_sync), .ka_sof_o(ka_sof),
    .traffic_ok_o(dbg_traffic_ok), .illegal_o(mode_illegal)
  );

  dbg_xact_regs #(.ADDR_W(ADDR_W), .EP_W(EP_W), .LEN_W(LEN_W), .DATA_W(DATA_W)) u_regs (
    .clk, .rst, .load(cfg_load), .addr_i(cfg_addr), .ep_i(cfg_endp),
    .pids_i(cfg_pids), .len_i(cfg_len), .data_i(cfg_data),
    .write_i(cfg_write), .go_i(cfg_go), .go_clr,
    .addr_o(r_addr), .ep_o(r_ep), .pids_o(r_pids), .len_o(r_len),
    .data_o(r_data), .go_o(go_busy), .start_o(start)
  );

  dbg_out_seq #(.ADDR_W(ADDR_W), .EP_W(EP_W), .DATA_BYTES(DATA_BYTES),
                .TIMEOUT_CYC(TIMEOUT_CYC)) u_seq (
    .clk, .rst, .go(go_busy), .start, .traffic_ok(dbg_traffic_ok),
    .addr(r_addr), .ep(r_ep), .pids(r_pids), .len(r_len), .data(r_data),
    .tx_ready, .hs_valid, .tx_valid, .tx_data, .tx_last, .go_clr,
    .done, .err_len, .err_to(err_timeout)
  );
endmodule

// File: rtl/usb_dbg_port_chk.sv
module usb_dbg_port_chk (
  input logic       clk,
  input logic       rst,
  input logic       owner,
  input logic       tx_valid,
  input logic [7:0] tx_data,
  input logic       tx_ready,
  input logic [2:0] port_mode,
  input logic       ka_sync,
  input logic       ka_sof,
  input logic       dbg_traffic_ok,
  input logic       mode_illegal,
  input logic       go_busy,
  input logic       done,
  input logic       err_len,
  input logic       err_timeout
);
  // R1
  owner_off_normal_chk: assert property (@(posedge clk) disable iff (rst)
    !owner |=> port_mode == 3'd0);

  // R2
  ka_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    !(ka_sync && ka_sof));

  // R3
  illegal_silent_chk: assert property (@(posedge clk) disable iff (rst)
    mode_illegal |-> !ka_sync && !ka_sof && !dbg_traffic_ok);

  // R8
  len_err_no_tx_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(err_len) |-> !tx_valid);

  // R9
  tx_hold_chk: assert property (@(posedge clk) disable iff (rst)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data));

  // R10
  done_clears_go_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |=> !go_busy && !err_timeout);
endmodule

bind usb_dbg_port_ctrl usb_dbg_port_chk chk_i (.*);

// File: tb/usb_dbg_port_ctrl_tb_top.sv
module usb_dbg_port_ctrl_tb_top;
  localparam int T = 16;

  logic clk = 0, rst = 1;
  logic owner = 0, dbg_en = 0, port_en = 0, run_stop = 0, suspend = 0;
  logic cfg_load = 0, cfg_write = 0, cfg_go = 0;
  logic [6:0] cfg_addr = 0;
  logic [3:0] cfg_endp = 0, cfg_len = 0;
  logic [15:0] cfg_pids = 0;
  logic [63:0] cfg_data = 0;
  logic tx_valid, tx_last, tx_ready = 1, hs_valid = 0;
  logic [7:0] tx_data;
  logic [2:0] port_mode;
  logic ka_sync, ka_sof, dbg_traffic_ok, mode_illegal, go_busy, done, err_len, err_timeout;

  int n_chk = 0, n_fail = 0, edge_n = 0, last_acc = 0;
  logic [7:0] got_q[$];
  logic       lst_q[$];
  logic rnd_rdy = 0, stall_prev = 0;
  logic [7:0] stall_data = 0;

  always #5 clk = ~clk;

  usb_dbg_port_ctrl #(.TIMEOUT_CYC(T)) dut_i (.*);

  task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    edge_n++;
    if (stall_prev) chk(tx_valid && tx_data == stall_data, "R9 hold", tx_data, stall_data);
    stall_prev = tx_valid && !tx_ready;
    stall_data = tx_data;
    if (tx_valid && tx_ready) begin
      got_q.push_back(tx_data);
      lst_q.push_back(tx_last);
      last_acc = edge_n;
    end
  end

  always @(negedge clk) tx_ready <= rnd_rdy ? (($urandom % 4) != 0) : 1'b1;

  function automatic logic [2:0] exp_mode(input logic o, e, p, r, s);
    if (!o || !e) return 3'd0;
    if (!p) return r ? 3'd2 : 3'd1;
    if (s) return 3'd5;
    return r ? 3'd3 : 3'd4;
  endfunction

  function automatic logic [7:0] exp_byte(input int i, input logic [6:0] a, input logic [3:0] e,
                                          input logic [15:0] p, input logic [63:0] d);
    case (i)
      0: return p[7:0];
      1: return {e[0], a};
      2: return {5'b0, e[3:1]};
      3: return p[15:8];
      default: return d[(i-4)*8 +: 8];
    endcase
  endfunction

  task automatic set_mode(input logic o, e, p, r, s);
    @(negedge clk);
    owner = o; dbg_en = e; port_en = p; run_stop = r; suspend = s;
    @(negedge clk);
  endtask

  task automatic load_cfg(input logic [6:0] a, input logic [3:0] e, input logic [15:0] p,
                          input logic [3:0] l, input logic [63:0] d, input logic w);
    @(negedge clk);
    cfg_addr = a; cfg_endp = e; cfg_pids = p; cfg_len = l; cfg_data = d;
    cfg_write = w; cfg_go = 1; cfg_load = 1;
    @(negedge clk);
    cfg_load = 0;
  endtask

  // expects bytes for image; hs_k = cycle in window (1..T), 0 = none
  task automatic finish_xfer(input logic [6:0] a, input logic [3:0] e, input logic [15:0] p,
                             input logic [3:0] l, input logic [63:0] d, input int hs_k);
    int nexp = 4 + l;
    int guard = 0;
    while (got_q.size() < nexp && guard < 2000) begin @(negedge clk); guard++; end
    chk(got_q.size() == nexp, "R6 R7 count", got_q.size(), nexp);
    for (int i = 0; i < nexp && i < got_q.size(); i++) begin
      chk(got_q[i] == exp_byte(i, a, e, p, d), (i < 3) ? "R6 token byte" : "R7 data byte",
          got_q[i], exp_byte(i, a, e, p, d));
      chk(lst_q[i] == (i == 2 || i == nexp - 1), "R6 R7 tx_last", lst_q[i], (i == 2 || i == nexp - 1));
    end
    if (hs_k > 0) begin
      while (edge_n < last_acc + hs_k - 1) @(negedge clk);
      hs_valid = 1;
      @(negedge clk);
      hs_valid = 0;
      chk(done && !err_timeout, "R10 done", {done, err_timeout}, 2'b10);
      @(negedge clk);
      chk(!go_busy, "R10 go cleared", go_busy, 0);
    end else begin
      while (edge_n < last_acc + T) @(negedge clk);
      chk(err_timeout && !done, "R11 timeout", {done, err_timeout}, 2'b01);
      hs_valid = 1;
      @(negedge clk);
      hs_valid = 0;
      @(negedge clk);
      chk(!done && !go_busy, "R11 late hs ignored", {done, go_busy}, 0);
    end
    got_q.delete(); lst_q.delete();
  endtask

  initial begin
    int unsigned sd = $urandom(32'h5eed);
    logic [6:0] a; logic [3:0] e, l; logic [15:0] p; logic [63:0] d;
    sd = sd;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(port_mode == 0 && !tx_valid && !go_busy && !done, "R1 reset", port_mode, 0);

    // mode table, all combinations
    for (int c = 0; c < 32; c++) begin
      logic [2:0] m;
      set_mode(c[4], c[3], c[2], c[1], c[0]);
      m = exp_mode(c[4], c[3], c[2], c[1], c[0]);
      chk(port_mode == m, (m == 0) ? "R1 mode" : (m < 3) ? "R2 mode" : "R3 mode", port_mode, m);
      chk(ka_sync == (m == 1) && ka_sof == (m == 2 || m == 3), "R2 keepalive", {ka_sync, ka_sof}, {m == 1, m == 2 || m == 3});
      chk(mode_illegal == (m == 4), "R3 illegal flag", mode_illegal, m == 4);
      chk(dbg_traffic_ok == (m >= 1 && m <= 3), "R4 traffic ok", dbg_traffic_ok, m >= 1 && m <= 3);
    end

    // R5 write bit 0 does not start
    set_mode(1, 1, 0, 1, 0);
    load_cfg(7'h12, 4'h3, 16'hC369, 4'd2, 64'h1122, 1'b0);
    repeat (5) @(negedge clk);
    chk(!go_busy && got_q.size() == 0, "R5 write=0 ignored", {go_busy, 8'(got_q.size())}, 0);

    // R8 length error
    load_cfg(7'h05, 4'h1, 16'hC32D, 4'd9, 64'hFF, 1'b1);
    repeat (3) @(negedge clk);
    chk(err_len && !go_busy && got_q.size() == 0, "R8 len error", {err_len, go_busy, 8'(got_q.size())}, 10'h200);

    // R13 flags clear on start, R5 go sets
    load_cfg(7'h7F, 4'hF, 16'hC3E1, 4'd0, 64'h0, 1'b1);
    chk(!err_len && go_busy, "R13 R5 start", {err_len, go_busy}, 2'b01);
    finish_xfer(7'h7F, 4'hF, 16'hC3E1, 4'd0, 64'h0, T);   // hs on final window cycle
    load_cfg(7'h01, 4'h2, 16'h4BE1, 4'd8, 64'h8877665544332211, 1'b1);
    finish_xfer(7'h01, 4'h2, 16'h4BE1, 4'd8, 64'h8877665544332211, 0);  // hs one cycle late
    load_cfg(7'h02, 4'h1, 16'hC3E1, 4'd1, 64'hAB, 1'b1);
    chk(!err_timeout, "R13 timeout flag cleared", err_timeout, 0);
    finish_xfer(7'h02, 4'h1, 16'hC3E1, 4'd1, 64'hAB, 1);

    // R4 R12: pending in illegal mode, second load ignored
    set_mode(1, 1, 1, 0, 0);
    load_cfg(7'h33, 4'h5, 16'hC3E1, 4'd3, 64'hCAFE01, 1'b1);
    load_cfg(7'h44, 4'h6, 16'h4B2D, 4'd5, 64'h99, 1'b1);
    repeat (10) @(negedge clk);
    chk(go_busy && got_q.size() == 0, "R4 held in illegal mode", {go_busy, 8'(got_q.size())}, 9'h100);
    set_mode(1, 1, 1, 1, 1);
    repeat (5) @(negedge clk);
    chk(got_q.size() == 0, "R4 held in suspend", got_q.size(), 0);
    set_mode(1, 1, 1, 1, 0);
    finish_xfer(7'h33, 4'h5, 16'hC3E1, 4'd3, 64'hCAFE01, 4);   // R12 original image

    // random traffic with stalls
    rnd_rdy = 1;
    for (int k = 0; k < 40; k++) begin
      a = 7'($urandom); e = 4'($urandom); p = 16'($urandom); l = 4'($urandom % 9);
      d = {$urandom, $urandom};
      if (k % 3 == 0) set_mode(1, 1, 0, k[1], 0);
      load_cfg(a, e, p, l, d, 1'b1);
      finish_xfer(a, e, p, l, d, (k % 7 == 6) ? 0 : 1 + int'($urandom % T));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #1ms;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule